// File: doc/BRIEF.md
# Parallel-Load Serial-Out Shift Register

This block is a cycle-accurate model of an eight-stage register that captures a byte in parallel and then hands it out one bit at a time. All of its control and data pins are treated as slow, asynchronous levels. The block samples them on a fast system clock, brings each one through a two-flop synchronizer, and finds shift events by edge detection on the sampled levels.

A low level on the active-low load pin copies the parallel byte into the stages. It keeps doing so every cycle for as long as the pin stays low. While load is high, the stages move one place toward the output on each rising edge of an effective shift clock. That clock is the OR of the shift-clock pin and the inhibit pin, so a rising edge on either of them shifts. The serial input fills stage 0 on each shift. The last stage drives the output, and a second output drives its complement.

A typical host loads a byte and releases load. It reads the output, then pulses the shift clock seven times, reading the output after each pulse, to recover the byte MSB first.

Top module: `piso_shift8`

## Requirements
- R1: While `load_n` is 0, the stages copy `par_in`, with bit i going to stage i. This holds whatever `sclk`, `inhibit` and `ser_in` are doing, including clock edges during the load.
- R2: While `load_n` is 1 and the OR of `sclk` and `inhibit` does not rise, the stages hold their contents.
- R3: With `load_n` at 1 and `inhibit` at 0, a 0-to-1 transition of `sclk` shifts the stages once.
- R4: With `load_n` at 1 and `sclk` at 0, a 0-to-1 transition of `inhibit` shifts the stages once.
- R5: A rising edge on `inhibit` while `sclk` is 1 does not shift the stages. A rising edge on `sclk` while `inhibit` is 1 does not shift them either.
- R6: On a shift, `ser_in` enters stage 0 and stage i moves to stage i+1. `q_out` shows stage 7, so right after a load it equals `par_in[7]`.
- R7: `q_out_n` is always the inverse of `q_out`.
- R8: When load goes low in the same sampled cycle as an effective rising edge, the load is applied and no shift is.
- R9: A synchronous active-high `rst` clears all stages and the edge history, so `q_out` is 0 and `q_out_n` is 1.
- R10: A pin change reaches the outputs on the third rising system clock edge after it is driven. Two of those edges are spent in the synchronizer and one in the stage register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | Shift clock pin (asynchronous) |
| inhibit | input | 1 | Clock-inhibit pin, ORed with sclk |
| load_n | input | 1 | Active-low parallel load |
| ser_in | input | 1 | Serial data into stage 0 |
| par_in | input | 8 | Parallel data, bit i to stage i |
| q_out | output | 1 | Last stage |
| q_out_n | output | 1 | Complement of the last stage |

## Verification
Only the last stage is visible at the ports, so a corrupted lower stage stays hidden until enough shifts carry it out. That takes at most seven shift edges, plus the three-cycle pin latency. A lost or doubled effective edge skews every later bit the output reports. A wrong load priority shows up in the output bit right after the load is released. For these reasons the bench compares the output against a pin-level model after every pin change. It also runs long random sequences, so that faults inside the register are shifted out to the output.

// File: rtl/piso_pkg.sv
package piso_pkg;

    typedef enum logic [1:0] {
        ACT_KEEP  = 2'd0,
        ACT_LOAD  = 2'd1,
        ACT_SHIFT = 2'd2
    } stage_act_e;

    typedef struct packed {
        logic sclk;
        logic inhibit;
        logic load_n;
        logic ser;
    } ctl_pins_t;

    localparam int CTL_W = $bits(ctl_pins_t);

endpackage

// File: rtl/piso_pin_sync.sv
module piso_pin_sync #(
    parameter int           W       = 1,
    parameter int           DEPTH   = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] stg;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.stg[0] = din;
        for (int i = 1; i < DEPTH; i++) begin
            st_d.stg[i] = st_q.stg[i-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                st_q.stg[i] <= RST_VAL;
            end
        end else begin
            st_q <= st_d;
        end
    end

    assign dout = st_q.stg[DEPTH-1];

    AST_SYNC_FIRST_STAGE: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> st_q.stg[0] == $past(din)) else $error("sync stage"); // R10

endmodule

// File: rtl/piso_edge_det.sv
module piso_edge_det (
    input  logic clk,
    input  logic rst,
    input  logic clk_a,
    input  logic clk_b,
    output logic rise
);
    typedef struct packed {
        logic or_prev;
    } edge_st_t;

    edge_st_t st_d, st_q;
    logic     or_now;

    always_comb begin
        or_now        = clk_a | clk_b;
        st_d          = st_q;
        st_d.or_prev  = or_now;
        rise          = or_now & ~st_q.or_prev;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.or_prev <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    AST_NO_BACK_TO_BACK_RISE: assert property (@(posedge clk) disable iff (rst)
        rise |=> !rise) else $error("double rise"); // R5

    AST_RISE_NEEDS_INPUT: assert property (@(posedge clk) disable iff (rst)
        rise |-> (clk_a || clk_b)) else $error("rise without input"); // R3

endmodule

// File: rtl/piso_stage_core.sv
module piso_stage_core
    import piso_pkg::*;
#(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_n,
    input  logic         rise,
    input  logic         ser,
    input  logic [N-1:0] par,
    output logic [N-1:0] stages
);
    typedef struct packed {
        logic [N-1:0] stg;
    } core_st_t;

    core_st_t   st_d, st_q;
    stage_act_e act;

    always_comb begin
        if (!load_n) begin
            act = ACT_LOAD;
        end else if (rise) begin
            act = ACT_SHIFT;
        end else begin
            act = ACT_KEEP;
        end

        st_d = st_q;
        unique case (act)
            ACT_LOAD:  st_d.stg = par;
            ACT_SHIFT: st_d.stg = {st_q.stg[N-2:0], ser};
            default:   st_d.stg = st_q.stg;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.stg <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign stages = st_q.stg;

    AST_LOAD_COPIES: assert property (@(posedge clk) disable iff (rst)
        !load_n |=> stages == $past(par)) else $error("load"); // R1

    AST_HOLD_WITHOUT_EDGE: assert property (@(posedge clk) disable iff (rst)
        (load_n && !rise) |=> $stable(stages)) else $error("hold"); // R2

    AST_SHIFT_MOVES: assert property (@(posedge clk) disable iff (rst)
        (load_n && rise) |=> (stages[N-1:1] == $past(stages[N-2:0])
                              && stages[0] == $past(ser))) else $error("shift"); // R6

endmodule

// File: rtl/piso_shift8.sv
module piso_shift8
    import piso_pkg::*;
#(
    parameter int N          = 8,
    parameter int SYNC_DEPTH = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         sclk,
    input  logic         inhibit,
    input  logic         load_n,
    input  logic         ser_in,
    input  logic [N-1:0] par_in,
    output logic         q_out,
    output logic         q_out_n
);
    localparam int PIN_W = CTL_W + N;
    localparam logic [PIN_W-1:0] PIN_RST = {1'b0, 1'b0, 1'b1, 1'b0, {N{1'b0}}};

    ctl_pins_t    ctl_raw, ctl_s;
    logic [N-1:0] par_s;
    logic [N-1:0] stages;
    logic         rise;

    always_comb begin
        ctl_raw.sclk    = sclk;
        ctl_raw.inhibit = inhibit;
        ctl_raw.load_n  = load_n;
        ctl_raw.ser     = ser_in;
    end

    piso_pin_sync #(
        .W       (PIN_W),
        .DEPTH   (SYNC_DEPTH),
        .RST_VAL (PIN_RST)
    ) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  ({ctl_raw, par_in}),
        .dout ({ctl_s, par_s})
    );

    piso_edge_det u_edge (
        .clk   (clk),
        .rst   (rst),
        .clk_a (ctl_s.sclk),
        .clk_b (ctl_s.inhibit),
        .rise  (rise)
    );

    piso_stage_core #(.N(N)) u_core (
        .clk    (clk),
        .rst    (rst),
        .load_n (ctl_s.load_n),
        .rise   (rise),
        .ser    (ctl_s.ser),
        .par    (par_s),
        .stages (stages)
    );

    assign q_out   = stages[N-1];
    assign q_out_n = ~stages[N-1];

    AST_OUT_COMPLEMENT: assert property (@(posedge clk) disable iff (rst)
        q_out_n != q_out) else $error("complement"); // R7

    AST_RESET_CLEARS: assert property (@(posedge clk)
        $past(rst) |-> (q_out == 1'b0)) else $error("reset"); // R9

    AST_LOAD_BEATS_EDGE: assert property (@(posedge clk) disable iff (rst)
        (!ctl_s.load_n && rise) |=> q_out == $past(par_s[N-1])) else $error("prio"); // R8

endmodule

// File: tb/piso_shift8_tb_top.sv
module piso_shift8_tb_top;
    logic       clk = 1'b0;
    logic       rst;
    logic       sclk, inhibit, load_n, ser_in;
    logic [7:0] par_in;
    logic       q_out, q_out_n;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    logic [7:0] model;
    logic       prev_or;

    always #5 clk = ~clk;

    piso_shift8 dut_i (
        .clk(clk), .rst(rst), .sclk(sclk), .inhibit(inhibit),
        .load_n(load_n), .ser_in(ser_in), .par_in(par_in),
        .q_out(q_out), .q_out_n(q_out_n)
    );

    function automatic logic [7:0] next_model(logic [7:0] cur, logic was_or,
                                              logic s, logic h, logic ld_n,
                                              logic d, logic [7:0] p);
        if (!ld_n)                return p;
        else if ((s | h) && !was_or) return {cur[6:0], d};
        else                      return cur;
    endfunction

    task automatic chk(string tag, logic act, logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic apply(string tag, logic s, logic h, logic ld_n, logic d, logic [7:0] p);
        @(negedge clk);
        sclk = s; inhibit = h; load_n = ld_n; ser_in = d; par_in = p;
        model   = next_model(model, prev_or, s, h, ld_n, d, p);
        prev_or = s | h;
        repeat (4) @(negedge clk);
        chk(tag, q_out, model[7]);
        chk("R7", q_out_n, ~model[7]);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240917));
        rst = 1'b1; sclk = 0; inhibit = 0; load_n = 1; ser_in = 0; par_in = 8'hFF;
        model = 8'h00; prev_or = 1'b0;
        repeat (5) @(negedge clk);
        chk("R9", q_out, 1'b0);
        chk("R9", q_out_n, 1'b1);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        chk("R9", q_out, 1'b0);

        // R1: load, with clock activity during the load
        apply("R1", 0, 0, 0, 0, 8'hA5);
        apply("R1", 1, 0, 0, 1, 8'hA5);
        apply("R1", 0, 1, 0, 1, 8'h25);
        apply("R1", 1, 1, 0, 0, 8'hA5);
        // R2: release load with OR already high -> no shift
        apply("R2", 1, 0, 1, 1, 8'h00);
        apply("R2", 1, 0, 1, 0, 8'hFF);
        // R3: sclk low then rising
        apply("R2", 0, 0, 1, 0, 8'h00);
        apply("R3", 1, 0, 1, 0, 8'h00);
        apply("R2", 0, 0, 1, 0, 8'h00);
        // R4: inhibit rising while sclk low
        apply("R4", 0, 1, 1, 1, 8'h00);
        // R5: sclk rising while inhibit high
        apply("R5", 1, 1, 1, 0, 8'h00);
        apply("R5", 0, 1, 1, 0, 8'h00);
        apply("R2", 0, 0, 1, 0, 8'h00);
        // R5: inhibit rising while sclk high
        apply("R3", 1, 0, 1, 1, 8'h00);
        apply("R5", 1, 1, 1, 1, 8'h00);
        apply("R2", 0, 0, 1, 1, 8'h00);

        // R6: load 0x6C then read out all bits, serial fill of ones
        apply("R6", 0, 0, 0, 0, 8'h6C);
        apply("R6", 0, 0, 1, 1, 8'h00);
        for (int i = 0; i < 10; i++) begin
            apply("R6", 1, 0, 1, 1, 8'h00);
            apply("R6", 0, 0, 1, 1, 8'h00);
        end

        // R8: load low in the same cycle as a rising effective edge
        apply("R8", 1, 0, 0, 0, 8'h80);
        apply("R8", 1, 0, 0, 0, 8'h80);
        apply("R8", 0, 0, 1, 0, 8'h00);
        apply("R8", 1, 0, 0, 1, 8'h00);

        // R10: latency of three system clock edges
        apply("R10", 0, 0, 0, 0, 8'h00);
        @(negedge clk);
        par_in = 8'h80;
        model  = 8'h80;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R10", q_out, 1'b0);
        @(posedge clk);
        @(negedge clk);
        chk("R10", q_out, 1'b1);
        repeat (3) @(negedge clk);

        // random sequences
        for (int k = 0; k < 400; k++) begin
            logic [31:0] r;
            r = $urandom;
            apply(r[3] ? "R6" : "R1", r[0], r[1] & r[4], r[2] | r[5], r[6], r[15:8]);
        end

        // reset mid-stream
        apply("R1", 0, 0, 0, 0, 8'hFF);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk("R9", q_out, 1'b0);
        sclk = 0; inhibit = 0; load_n = 1; ser_in = 0;
        @(negedge clk);
        rst = 1'b0;
        model = 8'h00; prev_or = 1'b0;
        repeat (4) @(negedge clk);
        chk("R9", q_out, 1'b0);
        chk("R7", q_out_n, 1'b1);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule